// File: doc/BRIEF.md
# Multi-speed data-strobe transmit encoder

This block turns parallel words from a link controller into a serial data-strobe pair for a cable line driver. A single fast clock runs the whole block. A one-cycle system-clock enable (`sys_ce`) marks every eighth fast cycle, and on each such cycle the block captures one word from `par_data`. The number of lanes captured depends on a speed code: 2 lanes at the lowest speed, 4 at the middle speed and 8 at the top speed. Because the word rate never changes, the lane count alone sets the serial bit rate: 2, 4 or 8 bits per system period. The fast clock is never switched.

The captured bits are sent lowest lane first. Each bit is held on the line for 4, 2 or 1 fast cycles. The strobe line changes in every bit period where the data line does not, so exactly one of the two lines changes per bit and the receiver can recover its clock from their XOR. A transmit enable frames the packet. The speed code is sampled only on the enable's rising edge. While the enable is low, both lines are held at 0 and all serializer state is cleared.

Top module: `ds_tx_encoder`

## Requirements
- R1: While `rst_n` is low or `tx_en` is low, `ser_data` and `ser_strobe` are 0. After `tx_en` rises, no bit appears on the lines before the first word has been captured, so nothing left over from an earlier packet is sent.
- R2: The speed code selects the lanes captured per word: 0 selects `par_data[1:0]`, 1 selects `par_data[3:0]` and 2 selects `par_data[7:0]`. The reserved code 3 behaves like code 0.
- R3: The captured bits of a word go out starting at lane 0 and rising by lane number. Successive words follow each other with no gap.
- R4: Each bit occupies 4 fast cycles under code 0 (and under code 3), 2 fast cycles under code 1 and 1 fast cycle under code 2.
- R5: In every bit period exactly one of `ser_data` and `ser_strobe` changes. The strobe changes when the new data bit equals the previous one. Outside a bit boundary both lines hold their values.
- R6: `speed_code` is sampled only in the cycle where `tx_en` rises. A change of the code later in the same packet has no effect on lane count or bit timing.
- R7: A word is captured at the clock edge where `sys_ce` and `tx_en` are both high, including the edge where `tx_en` rises. Its first bit reaches the lines after the next clock edge.
- R8: Lanes above the selected count, and `par_data` values in cycles without `sys_ce`, never reach the lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast serial clock, eight times the system rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_ce | input | 1 | One-cycle enable marking each system-clock point |
| tx_en | input | 1 | Transmit enable; frames a packet |
| speed_code | input | 2 | 0 = 2 lanes, 1 = 4 lanes, 2 = 8 lanes, 3 = as 0 |
| par_data | input | LANES (8) | Parallel word from the link controller |
| ser_data | output | 1 | Serial data line |
| ser_strobe | output | 1 | Serial strobe line |

## Verification
A wrong phase count or shift step shows up at the lines within one bit period. Either the XOR of data and strobe toggles at the wrong spacing, or a bit is sent twice or skipped, and the decoded stream then stops matching the captured lanes within the same word. A speed latch that follows the code in mid-packet changes the toggle spacing at once. A serializer that still holds state after the enable falls sends toggles in the first cycles after a re-enable that lands between system points, before any word has been captured.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;

  typedef enum logic [1:0] {
    SPD_S100 = 2'd0,
    SPD_S200 = 2'd1,
    SPD_S400 = 2'd2,
    SPD_RSVD = 2'd3
  } spd_e;

  // log2 of fast cycles per serial bit; reserved code runs at the lowest rate
  function automatic int hold_log2(spd_e s);
    case (s)
      SPD_S400: return 0;
      SPD_S200: return 1;
      default:  return 2;
    endcase
  endfunction

  // strobe flips whenever the data line would not
  function automatic logic next_strobe(logic b_new, logic data_prev, logic strobe_prev);
    return strobe_prev ^ (b_new ~^ data_prev);
  endfunction

endpackage

// File: rtl/ds_tx_ctrl.sv
module ds_tx_ctrl
  import ds_tx_pkg::*;
#(
  parameter int PH_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_ce,
  input  logic       tx_en,
  input  logic [1:0] speed_code,
  output spd_e       spd_cur,
  output logic       load,
  output logic       shift,
  output logic       emit
);

  logic            tx_en_d;
  logic            active;
  logic            rise;
  spd_e            spd_q;
  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] hold_mask;

  assign rise      = tx_en & ~tx_en_d;
  assign spd_cur   = rise ? spd_e'(speed_code) : spd_q;
  assign hold_mask = PH_W'((1 << hold_log2(spd_cur)) - 1);
  assign load      = sys_ce & tx_en;
  assign shift     = active & tx_en & ~load & ((ph & hold_mask) == hold_mask);
  assign emit      = active & tx_en & ((ph & hold_mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_d <= 1'b0;
      spd_q   <= SPD_S100;
      active  <= 1'b0;
      ph      <= '0;
    end else begin
      tx_en_d <= tx_en;
      if (rise) spd_q <= spd_e'(speed_code);
      if (!tx_en) begin
        active <= 1'b0;
        ph     <= '0;
      end else if (load) begin
        active <= 1'b1;
        ph     <= '0;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  AST_SPEED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && tx_en_d) |=> (spd_q == $past(spd_q))); // R6

  AST_BIT_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && (spd_cur != SPD_S400)) |=> !emit); // R4

endmodule

// File: rtl/ds_tx_shifter.sv
module ds_tx_shifter
  import ds_tx_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             load,
  input  logic             shift,
  input  spd_e             spd,
  input  logic [LANES-1:0] word,
  output logic             cur_bit
);

  logic [LANES-1:0] shreg;
  logic [LANES-1:0] lane_mask;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    assign lane_mask[gi] = (gi < (LANES >> hold_log2(spd)));
  end

  assign cur_bit = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shreg <= '0;
    else if (!tx_en) shreg <= '0;
    else if (load)   shreg <= word & lane_mask;
    else if (shift)  shreg <= shreg >> 1;
  end

  AST_SHREG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (shreg == '0)); // R1

endmodule

// File: rtl/ds_tx_line.sv
module ds_tx_line
  import ds_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic emit,
  input  logic bit_in,
  output logic data_q,
  output logic strobe_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else if (!tx_en) begin
      data_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else if (emit) begin
      data_q   <= bit_in;
      strobe_q <= next_strobe(bit_in, data_q, strobe_q);
    end
  end

  AST_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> ((data_q ^ strobe_q) != $past(data_q ^ strobe_q))); // R5

  AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !emit) |=> ($stable(data_q) && $stable(strobe_q))); // R5

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!data_q && !strobe_q)); // R1

endmodule

// File: rtl/ds_tx_encoder.sv
module ds_tx_encoder
  import ds_tx_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_ce,
  input  logic             tx_en,
  input  logic [1:0]       speed_code,
  input  logic [LANES-1:0] par_data,
  output logic             ser_data,
  output logic             ser_strobe
);

  localparam int PH_W = $clog2(LANES);

  spd_e spd_cur;
  logic load;
  logic shift;
  logic emit;
  logic cur_bit;
  logic data_q;
  logic strobe_q;

  ds_tx_ctrl #(.PH_W(PH_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_ce     (sys_ce),
    .tx_en      (tx_en),
    .speed_code (speed_code),
    .spd_cur    (spd_cur),
    .load       (load),
    .shift      (shift),
    .emit       (emit)
  );

  ds_tx_shifter #(.LANES(LANES)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .load    (load),
    .shift   (shift),
    .spd     (spd_cur),
    .word    (par_data),
    .cur_bit (cur_bit)
  );

  ds_tx_line u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .emit     (emit),
    .bit_in   (cur_bit),
    .data_q   (data_q),
    .strobe_q (strobe_q)
  );

  assign ser_data   = data_q & tx_en;
  assign ser_strobe = strobe_q & tx_en;

endmodule

// File: tb/tb_ds_tx_encoder.sv
module tb_ds_tx_encoder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_ce = 1'b0;
  logic       tx_en = 1'b0;
  logic [1:0] speed_code = 2'd0;
  logic [7:0] par_data = 8'd0;
  logic       ser_data;
  logic       ser_strobe;

  always #5 clk = ~clk;

  ds_tx_encoder dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_ce     (sys_ce),
    .tx_en      (tx_en),
    .speed_code (speed_code),
    .par_data   (par_data),
    .ser_data   (ser_data),
    .ser_strobe (ser_strobe)
  );

  // {code_after, code_start, w3, w2, w1, w0}
  localparam logic [35:0] VEC [8] = '{
    {2'd0, 2'd0, 8'hFE, 8'h01, 8'h3C, 8'hA5},
    {2'd1, 2'd1, 8'h0F, 8'hF0, 8'hC3, 8'h5A},
    {2'd2, 2'd2, 8'h00, 8'hFF, 8'h69, 8'h96},
    {2'd2, 2'd2, 8'h00, 8'h00, 8'h00, 8'h00},
    {2'd2, 2'd2, 8'hFF, 8'hFF, 8'hFF, 8'hFF},
    {2'd3, 2'd3, 8'h1D, 8'hE2, 8'h48, 8'hB7},
    {2'd2, 2'd0, 8'hD4, 8'h2B, 8'h93, 8'h6C},
    {2'd0, 2'd2, 8'hBD, 8'h42, 8'h7E, 8'h81}
  };

  int checks = 0, fails = 0;
  int cyc = 0, tk = 0, gap = 0, nrec = 0, first_tk = -1;
  int bad_gap = 0, bad_r5 = 0, exp_gap = 1;
  logic prev_d = 1'b0, prev_s = 1'b0;
  logic [31:0] rec_bits = '0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one fast cycle: sample at the falling edge, decode, advance the system phase
  task automatic tick();
    @(negedge clk);
    if (tx_en) begin
      if ((ser_data ^ ser_strobe) != (prev_d ^ prev_s)) begin
        if ((ser_data != prev_d) && (ser_strobe != prev_s)) bad_r5++;
        if (nrec == 0) first_tk = tk + 1;
        else if (gap != exp_gap) bad_gap++;
        if (nrec < 32) rec_bits[nrec] = ser_data;
        nrec++;
        gap = 0;
      end else if ((ser_data != prev_d) || (ser_strobe != prev_s)) begin
        bad_r5++;
      end
      gap++;
    end
    prev_d = ser_data;
    prev_s = ser_strobe;
    tk++;
    cyc++;
    sys_ce = (cyc % 8 == 0);
  endtask

  task automatic send(input logic [35:0] v);
    logic [1:0]  code;
    logic [1:0]  after;
    int          nb;
    int          idx;
    logic [31:0] exp_bits;
    logic [31:0] msk;
    code  = v[33:32];
    after = v[35:34];
    nb    = (code == 2'd2) ? 8 : (code == 2'd1) ? 4 : 2;
    exp_bits = '0;
    idx = 0;
    for (int w = 0; w < 4; w++)
      for (int j = 0; j < nb; j++) begin
        exp_bits[idx] = v[8*w + j];
        idx++;
      end
    msk = (nb == 8) ? 32'hFFFF_FFFF : ((32'd1 << (4*nb)) - 1);
    while (cyc % 8 != 0) tick();
    nrec = 0; tk = 0; gap = 0; first_tk = -1; bad_gap = 0; bad_r5 = 0;
    exp_gap = 8 / nb; rec_bits = '0;
    tx_en = 1'b1; speed_code = code; par_data = v[7:0];
    for (int w = 1; w < 4; w++)
      for (int k = 0; k < 8; k++) begin
        tick();
        if (w == 1 && k == 0) speed_code = after;
        par_data = (cyc % 8 == 0) ? v[8*w +: 8] : 8'($urandom);
      end
    for (int k = 0; k < 8; k++) begin
      tick();
      par_data = 8'($urandom);
    end
    tick();
    tx_en = 1'b0;
    chk(nrec == 4*nb, "R2", "bit count for speed code", nrec, 4*nb);
    chk((rec_bits & msk) == exp_bits, "R3/R8", "decoded bit stream", rec_bits & msk, exp_bits);
    chk(bad_gap == 0, (after != code) ? "R6/R4" : "R4", "bad bit spacing count", bad_gap, 0);
    chk(bad_r5 == 0, "R5", "bit periods without a single-line change", bad_r5, 0);
    chk(first_tk == 2, "R7", "cycles to first bit", first_tk, 2);
    tick();
    tick();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int nz;
    // R1: reset state
    repeat (3) tick();
    chk(!ser_data && !ser_strobe, "R1", "lines during reset", {ser_data, ser_strobe}, 0);
    rst_n = 1'b1;
    // R1: enable low ignores data, code and system points
    nz = 0;
    for (int k = 0; k < 24; k++) begin
      par_data = 8'($urandom);
      speed_code = 2'($urandom);
      tick();
      if (ser_data || ser_strobe) nz++;
    end
    chk(nz == 0, "R1", "non-zero samples with enable low", nz, 0);

    // table of packets
    for (int i = 0; i < 8; i++) send(VEC[i]);

    // R1: abort mid-packet, then re-enable between system points
    while (cyc % 8 != 0) tick();
    tx_en = 1'b1; speed_code = 2'd2; par_data = 8'hFF;
    tick(); tick(); tick();
    tx_en = 1'b0;
    tick();
    chk(!ser_data && !ser_strobe, "R1", "lines after enable drop", {ser_data, ser_strobe}, 0);
    while (cyc % 8 != 3) tick();
    tx_en = 1'b1; speed_code = 2'd0; par_data = 8'hAA;
    nz = 0;
    while (cyc % 8 != 0) begin
      tick();
      if (ser_data || ser_strobe) nz++;
    end
    par_data = 8'h00;
    tick();
    if (ser_data || ser_strobe) nz++;
    chk(nz == 0, "R1", "residue toggles before first capture", nz, 0);
    tx_en = 1'b0;
    tick();

    // a packet after the abort still decodes cleanly
    send({2'd1, 2'd1, 8'h3A, 8'hC5, 8'h9E, 8'h71});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule